// File: doc/BRIEF.md
# Program Counter and Call-Stack Sequencer

This block works out the next program-counter value for a small 8-bit controller core and carries out the stack traffic for subroutine calls and returns. The surrounding core latches a request with a one-cycle `start` strobe. The request carries an operation code, the address of the current instruction, the instruction's page-select bits, its second and third bytes, a branch-taken condition and an instruction length. The sequencer then runs a short fixed sequence. It raises `done` for one cycle in the same cycle that `pc_out` shows the new program counter.

There are two kinds of target. An in-page target keeps the top five bits of the advanced PC and replaces the low eleven bits with the three page-select bits and the second byte. A long target takes all sixteen bits from the two operand bytes. Calls push the return address onto a pre-incrementing stack, low byte first, through a byte-wide port to an external 256-byte RAM. Returns pop the high byte and then the low byte. The RAM returns read data one cycle after a read strobe. The stack pointer resets to a parameterised value, 07h by default.

Top module: `pc_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `pc_out` to 0000h, sets `sp_out` to 07h and drives `done`, `busy`, `intr_exit`, `mem_we` and `mem_re` low.
- R2: Operation 0 (in-page jump) adds 2 to `cur_pc`. The new PC is the top five bits of that sum, then `page_bits` as bits 10..8, then `byte2` as bits 7..0. The operation makes no memory access and leaves SP unchanged. This rule applies even when the addition crosses a 2 KB boundary.
- R3: Operation 1 (in-page call) forms its target as in R2 and pushes `cur_pc`+2. It first writes the low byte to address SP+1, then writes the high byte to address SP+2 on the following cycle. It ends with SP increased by 2.
- R4: Operation 2 (long jump) loads `{byte2, byte3}` into the PC and makes no memory access.
- R5: Operation 3 (long call) pushes `cur_pc`+3 in the same order as R3 and then loads `{byte2, byte3}` into the PC.
- R6: Operation 4 (relative branch) advances the PC by `inst_len` (2 or 3). When `taken` is high, it also adds the sign-extended displacement. The displacement is `byte3` when `inst_len` is 3 and `byte2` otherwise.
- R7: Operation 5 (return) reads RAM[SP] as PC[15:8], then on the next cycle reads RAM[SP-1] as PC[7:0]. It ends with SP decreased by 2. Read data is expected on `mem_rdata` one cycle after `mem_re`.
- R8: Operation 6 (interrupt return) behaves as R7 and also raises `intr_exit` together with `done`. No other operation raises `intr_exit`.
- R9: Stack-pointer arithmetic wraps modulo 256 in both directions. PC arithmetic wraps modulo 65536.
- R10: `done` is a single-cycle pulse that appears when `pc_out` takes its new value. Counted in clock edges from the edge that samples `start`, it arrives 2 edges later for jumps and branches and 4 edges later for calls and returns.
- R11: A `start` that arrives while `busy` is high has no effect on the operation in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, accepted only when idle |
| op_sel | input | 3 | Operation code (0..6) |
| cur_pc | input | 16 | Address of the current instruction |
| page_bits | input | 3 | Opcode bits 7..5 for in-page targets |
| byte2 | input | 8 | Second instruction byte |
| byte3 | input | 8 | Third instruction byte |
| taken | input | 1 | Branch condition |
| inst_len | input | 2 | Branch instruction length |
| pc_out | output | 16 | Program counter result |
| sp_out | output | 8 | Stack pointer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| intr_exit | output | 1 | Pulse with `done` for an interrupt return |
| mem_addr | output | 8 | RAM byte address |
| mem_we | output | 1 | RAM write strobe |
| mem_wdata | output | 8 | RAM write data |
| mem_re | output | 1 | RAM read strobe |
| mem_rdata | input | 8 | RAM read data, one cycle after `mem_re` |

## Verification
A corrupted stack pointer appears on `sp_out` in the next cycle. It also appears on `mem_addr` at the next push or pop, so the stack bytes land at the wrong places or the popped PC comes out wrong. A sequencer stuck in the wrong state shows as a `done` latency other than 2 or 4 edges, or as missing or extra memory strobes. A bad capture of the popped high byte shows only in `pc_out` when `done` rises. The wrap cases are driven so that a width error in either counter appears as a wrong address at the 00h/FFh boundary.

// File: rtl/pcseq_pkg.sv
// Shared types for the program-counter sequencer.
// Assumes a 3-bit operation code supplied by the core's decoder.
package pcseq_pkg;

    typedef enum logic [2:0] {
        OP_AJMP   = 3'd0,
        OP_ACALL  = 3'd1,
        OP_LJMP   = 3'd2,
        OP_LCALL  = 3'd3,
        OP_BRANCH = 3'd4,
        OP_RET    = 3'd5,
        OP_RETI   = 3'd6
    } pcseq_op_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PUSH_LO = 3'd1,
        ST_PUSH_HI = 3'd2,
        ST_POP_HI  = 3'd3,
        ST_POP_LO  = 3'd4,
        ST_POP_END = 3'd5,
        ST_FINISH  = 3'd6
    } pcseq_state_e;

    function automatic logic op_is_call(pcseq_op_e op);
        return (op == OP_ACALL) || (op == OP_LCALL);
    endfunction

    function automatic logic op_is_return(pcseq_op_e op);
        return (op == OP_RET) || (op == OP_RETI);
    endfunction

endpackage

// File: rtl/pcseq_target.sv
// Target computation: purely combinational.
// Produces the advanced (return) PC and the jump/branch target from the
// latched request. Assumes PC_W is a whole number of DATA_W bytes and
// PAGE_W lies between DATA_W and PC_W.
module pcseq_target
    import pcseq_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 11
) (
    input  pcseq_op_e                        op,
    input  logic [PC_W-1:0]                  cur_pc,
    input  logic [PAGE_W-DATA_W-1:0]         page_bits,
    input  logic [DATA_W-1:0]                byte2,
    input  logic [DATA_W-1:0]                byte3,
    input  logic                             taken,
    input  logic [1:0]                       inst_len,
    output logic [PC_W-1:0]                  ret_pc,
    output logic [PC_W-1:0]                  target,
    output logic [PC_W/DATA_W-1:0][DATA_W-1:0] ret_bytes
);
    localparam int NBYTES = PC_W / DATA_W;

    logic [1:0]        adv;
    logic [DATA_W-1:0] rel_byte;
    logic [PC_W-1:0]   rel_ext;

    // Select how far the PC advances past the current instruction.
    always_comb begin
        case (op)
            OP_AJMP, OP_ACALL: adv = 2'd2;
            OP_LJMP, OP_LCALL: adv = 2'd3;
            OP_BRANCH:         adv = inst_len;
            default:           adv = 2'd0;
        endcase
    end

    assign ret_pc   = cur_pc + {{(PC_W-2){1'b0}}, adv};
    assign rel_byte = (inst_len == 2'd3) ? byte3 : byte2;
    assign rel_ext  = {{(PC_W-DATA_W){rel_byte[DATA_W-1]}}, rel_byte};

    // Build the destination for each kind of transfer.
    always_comb begin
        case (op)
            OP_AJMP, OP_ACALL: target = {ret_pc[PC_W-1:PAGE_W], page_bits, byte2};
            OP_LJMP, OP_LCALL: target = {byte2, byte3};
            OP_BRANCH:         target = taken ? (ret_pc + rel_ext) : ret_pc;
            default:           target = ret_pc;
        endcase
    end

    // Slice the return address into bytes for the push sequence.
    for (genvar g = 0; g < NBYTES; g++) begin : g_ret_byte
        assign ret_bytes[g] = ret_pc[g*DATA_W +: DATA_W];
    end

endmodule

// File: rtl/pcseq_sp.sv
// Stack pointer register.
// Increments or decrements by one per cycle and wraps modulo 2**SP_W.
// Assumes the controller never asks for both steps at once.
module pcseq_sp #(
    parameter int          SP_W   = 8,
    parameter logic [SP_W-1:0] SP_RST = 8'h07
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inc,
    input  logic            dec,
    output logic [SP_W-1:0] sp,
    output logic [SP_W-1:0] sp_up
);
    logic [SP_W-1:0] sp_q;

    assign sp    = sp_q;
    assign sp_up = sp_q + SP_W'(1);

    // Step the pointer on push or pop cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)   sp_q <= SP_RST;
        else if (inc) sp_q <= sp_up;
        else if (dec) sp_q <= sp_q - SP_W'(1);
    end

    p_sp_single_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc && dec));

endmodule

// File: rtl/pcseq_ctrl.sv
// Sequencer state machine.
// Accepts a request only in idle, then walks a fixed path:
// jumps finish directly, calls push two bytes, returns pop two bytes and
// wait one cycle for the read data. Emits registered done/intr_exit pulses.
module pcseq_ctrl
    import pcseq_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  pcseq_op_e    op_i,
    output pcseq_state_e state,
    output logic         accept,
    output logic         sp_inc,
    output logic         sp_dec,
    output logic         busy,
    output logic         done,
    output logic         intr_exit
);
    pcseq_state_e state_q, state_d;
    logic         reti_q;
    logic         done_q, intr_q;

    assign state     = state_q;
    assign accept    = (state_q == ST_IDLE) && start;
    assign busy      = (state_q != ST_IDLE);
    assign sp_inc    = (state_q == ST_PUSH_LO) || (state_q == ST_PUSH_HI);
    assign sp_dec    = (state_q == ST_POP_HI)  || (state_q == ST_POP_LO);
    assign done      = done_q;
    assign intr_exit = intr_q;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (op_is_call(op_i))        state_d = ST_PUSH_LO;
                    else if (op_is_return(op_i)) state_d = ST_POP_HI;
                    else                         state_d = ST_FINISH;
                end
            end
            ST_PUSH_LO: state_d = ST_PUSH_HI;
            ST_PUSH_HI: state_d = ST_FINISH;
            ST_POP_HI:  state_d = ST_POP_LO;
            ST_POP_LO:  state_d = ST_POP_END;
            ST_POP_END: state_d = ST_IDLE;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            reti_q  <= 1'b0;
            done_q  <= 1'b0;
            intr_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) reti_q <= (op_i == OP_RETI);
            done_q  <= (state_q == ST_FINISH) || (state_q == ST_POP_END);
            intr_q  <= (state_q == ST_POP_END) && reti_q;
        end
    end

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    p_intr_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        intr_exit |-> done);

endmodule

// File: rtl/pc_seq.sv
// Program counter and call-stack sequencer (top).
// Latches a request on an idle start, computes the target, drives the
// byte-wide stack RAM port and updates the PC register with a done pulse.
// Assumes an external RAM with write on the strobe edge and registered
// read data one cycle after mem_re.
module pc_seq
    import pcseq_pkg::*;
#(
    parameter int          DATA_W   = 8,
    parameter int          PAGE_W   = 11,
    parameter logic [7:0]  SP_RESET = 8'h07
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [2:0]               op_sel,
    input  logic [2*DATA_W-1:0]      cur_pc,
    input  logic [PAGE_W-DATA_W-1:0] page_bits,
    input  logic [DATA_W-1:0]        byte2,
    input  logic [DATA_W-1:0]        byte3,
    input  logic                     taken,
    input  logic [1:0]               inst_len,
    output logic [2*DATA_W-1:0]      pc_out,
    output logic [DATA_W-1:0]        sp_out,
    output logic                     busy,
    output logic                     done,
    output logic                     intr_exit,
    output logic [DATA_W-1:0]        mem_addr,
    output logic                     mem_we,
    output logic [DATA_W-1:0]        mem_wdata,
    output logic                     mem_re,
    input  logic [DATA_W-1:0]        mem_rdata
);
    localparam int PC_W    = 2 * DATA_W;
    localparam int SP_W    = DATA_W;
    localparam int FIELD_W = PAGE_W - DATA_W;
    localparam int NBYTES  = PC_W / DATA_W;

    pcseq_state_e state;
    logic         accept, sp_inc, sp_dec;
    logic [SP_W-1:0] sp, sp_up;

    pcseq_op_e            op_q;
    logic [PC_W-1:0]      pc_lat;
    logic [FIELD_W-1:0]   page_q;
    logic [DATA_W-1:0]    b2_q, b3_q, hi_q;
    logic                 taken_q;
    logic [1:0]           len_q;
    logic [PC_W-1:0]      pc_q;

    logic [PC_W-1:0]                 ret_pc, target;
    logic [NBYTES-1:0][DATA_W-1:0]   ret_bytes;

    pcseq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_i      (pcseq_op_e'(op_sel)),
        .state     (state),
        .accept    (accept),
        .sp_inc    (sp_inc),
        .sp_dec    (sp_dec),
        .busy      (busy),
        .done      (done),
        .intr_exit (intr_exit)
    );

    pcseq_sp #(.SP_W(SP_W), .SP_RST(SP_RESET)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (sp_inc),
        .dec   (sp_dec),
        .sp    (sp),
        .sp_up (sp_up)
    );

    pcseq_target #(.PC_W(PC_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_target (
        .op        (op_q),
        .cur_pc    (pc_lat),
        .page_bits (page_q),
        .byte2     (b2_q),
        .byte3     (b3_q),
        .taken     (taken_q),
        .inst_len  (len_q),
        .ret_pc    (ret_pc),
        .target    (target),
        .ret_bytes (ret_bytes)
    );

    // Capture the request fields when the controller accepts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_AJMP;
            pc_lat  <= '0;
            page_q  <= '0;
            b2_q    <= '0;
            b3_q    <= '0;
            taken_q <= 1'b0;
            len_q   <= 2'd0;
        end else if (accept) begin
            op_q    <= pcseq_op_e'(op_sel);
            pc_lat  <= cur_pc;
            page_q  <= page_bits;
            b2_q    <= byte2;
            b3_q    <= byte3;
            taken_q <= taken;
            len_q   <= inst_len;
        end
    end

    // Hold the popped high byte and load the final PC value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            pc_q <= '0;
        end else begin
            if (state == ST_POP_LO) hi_q <= mem_rdata;
            if (state == ST_FINISH)       pc_q <= target;
            else if (state == ST_POP_END) pc_q <= {hi_q, mem_rdata};
        end
    end

    assign pc_out    = pc_q;
    assign sp_out    = sp;
    assign mem_we    = (state == ST_PUSH_LO) || (state == ST_PUSH_HI);
    assign mem_re    = (state == ST_POP_HI)  || (state == ST_POP_LO);
    assign mem_addr  = mem_we ? sp_up : sp;
    assign mem_wdata = (state == ST_PUSH_LO) ? ret_bytes[0] : ret_bytes[NBYTES-1];

    p_push_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + SP_W'(1)));

    p_pop_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) - SP_W'(1)));

    p_no_rw_clash_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    p_hold_request_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(op_q) && $stable(pc_lat) && $stable(b2_q)));

endmodule

// File: tb/pc_seq_tb.sv
module pc_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic [15:0] cur_pc = 16'h0;
    logic [2:0]  page_bits = 3'd0;
    logic [7:0]  byte2 = 8'h0, byte3 = 8'h0;
    logic        taken = 1'b0;
    logic [1:0]  inst_len = 2'd0;
    logic [15:0] pc_out;
    logic [7:0]  sp_out, mem_addr, mem_wdata;
    logic [7:0]  mem_rdata = 8'h0;
    logic        busy, done, intr_exit, mem_we, mem_re;

    logic [7:0] ram [256];
    int errors = 0;
    int checks = 0;
    int we_cnt = 0;
    int re_cnt = 0;

    always #5 clk = ~clk;

    pc_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .cur_pc(cur_pc), .page_bits(page_bits), .byte2(byte2), .byte3(byte3),
        .taken(taken), .inst_len(inst_len), .pc_out(pc_out), .sp_out(sp_out),
        .busy(busy), .done(done), .intr_exit(intr_exit), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_re(mem_re),
        .mem_rdata(mem_rdata)
    );

    // RAM model: write on the edge, registered read.
    always @(posedge clk) begin
        if (mem_we) begin
            ram[mem_addr] <= mem_wdata;
            we_cnt <= we_cnt + 1;
        end
        if (mem_re) begin
            mem_rdata <= ram[mem_addr];
            re_cnt <= re_cnt + 1;
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [15:0] pc,
                          input logic [2:0] pg, input logic [7:0] b2, input logic [7:0] b3,
                          input logic tk, input logic [1:0] ln,
                          output int lat, output logic ie);
        @(negedge clk);
        op_sel = op; cur_pc = pc; page_bits = pg; byte2 = b2; byte3 = b3;
        taken = tk; inst_len = ln; start = 1'b1;
        we_cnt = 0; re_cnt = 0;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 16) begin
            @(negedge clk);
            lat++;
        end
        ie = intr_exit;
    endtask

    task automatic t_reset();
        chk("R1", "pc", pc_out, 16'h0000);
        chk("R1", "sp", sp_out, 8'h07);
        chk("R1", "flags", {done, busy, intr_exit, mem_we, mem_re}, 5'b0);
    endtask

    task automatic t_abs_call();
        int lat; logic ie;
        run_op(3'd1, 16'h0123, 3'd3, 8'h45, 8'h00, 1'b0, 2'd0, lat, ie);
        chk("R3", "pc", pc_out, 16'h0345);
        chk("R3", "sp", sp_out, 8'h09);
        chk("R3", "ram08 low byte", ram[8'h08], 8'h25);
        chk("R3", "ram09 high byte", ram[8'h09], 8'h01);
        chk("R3", "writes", we_cnt, 2);
        chk("R10", "call latency", lat, 4);
    endtask

    task automatic t_abs_jump();
        int lat; logic ie;
        run_op(3'd0, 16'h07FE, 3'd7, 8'h10, 8'h00, 1'b0, 2'd0, lat, ie);
        chk("R2", "page cross pc", pc_out, 16'h0F10);
        chk("R2", "sp", sp_out, 8'h09);
        chk("R2", "no traffic", we_cnt + re_cnt, 0);
        chk("R10", "jump latency", lat, 2);
        run_op(3'd0, 16'h0345, 3'd1, 8'h23, 8'h00, 1'b0, 2'd0, lat, ie);
        chk("R2", "pc", pc_out, 16'h0123);
    endtask

    task automatic t_long_call();
        int lat; logic ie;
        run_op(3'd3, 16'h1FFE, 3'd0, 8'hAB, 8'hCD, 1'b0, 2'd0, lat, ie);
        chk("R5", "pc", pc_out, 16'hABCD);
        chk("R5", "sp", sp_out, 8'h0B);
        chk("R5", "ram0A", ram[8'h0A], 8'h01);
        chk("R5", "ram0B", ram[8'h0B], 8'h20);
        chk("R10", "lcall latency", lat, 4);
    endtask

    task automatic t_long_jump();
        int lat; logic ie;
        run_op(3'd2, 16'h5000, 3'd5, 8'h12, 8'h34, 1'b1, 2'd3, lat, ie);
        chk("R4", "pc", pc_out, 16'h1234);
        chk("R4", "sp", sp_out, 8'h0B);
        chk("R4", "no traffic", we_cnt + re_cnt, 0);
    endtask

    task automatic t_branch();
        int lat; logic ie;
        run_op(3'd4, 16'h0100, 3'd0, 8'h55, 8'hFB, 1'b1, 2'd3, lat, ie);
        chk("R6", "3-byte back", pc_out, 16'h00FE);
        chk("R10", "branch latency", lat, 2);
        run_op(3'd4, 16'h0200, 3'd0, 8'h10, 8'hEE, 1'b1, 2'd2, lat, ie);
        chk("R6", "2-byte fwd", pc_out, 16'h0212);
        run_op(3'd4, 16'h0300, 3'd0, 8'h10, 8'h80, 1'b0, 2'd3, lat, ie);
        chk("R6", "not taken", pc_out, 16'h0303);
        run_op(3'd4, 16'hFFFE, 3'd0, 8'h05, 8'h00, 1'b1, 2'd2, lat, ie);
        chk("R9", "pc wrap", pc_out, 16'h0005);
    endtask

    task automatic t_return();
        int lat; logic ie;
        run_op(3'd5, 16'h0000, 3'd0, 8'h00, 8'h00, 1'b0, 2'd0, lat, ie);
        chk("R7", "pc", pc_out, 16'h2001);
        chk("R7", "sp", sp_out, 8'h09);
        chk("R7", "reads", re_cnt, 2);
        chk("R10", "return latency", lat, 4);
        chk("R8", "no intr_exit on plain return", ie, 1'b0);
    endtask

    task automatic t_reti();
        int lat; logic ie;
        run_op(3'd6, 16'h0000, 3'd0, 8'h00, 8'h00, 1'b0, 2'd0, lat, ie);
        chk("R8", "pc", pc_out, 16'h0125);
        chk("R8", "sp", sp_out, 8'h07);
        chk("R8", "intr_exit", ie, 1'b1);
        @(negedge clk);
        chk("R10", "done single cycle", {done, intr_exit}, 2'b00);
    endtask

    task automatic t_wrap();
        int lat; logic ie;
        @(negedge clk);
        ram[8'h01] = 8'h3C;
        ram[8'h00] = 8'h7A;
        for (int i = 0; i < 4; i++)
            run_op(3'd5, 16'h0000, 3'd0, 8'h00, 8'h00, 1'b0, 2'd0, lat, ie);
        chk("R9", "pop wrap pc", pc_out, 16'h3C7A);
        chk("R9", "pop wrap sp", sp_out, 8'hFF);
        run_op(3'd1, 16'h0000, 3'd0, 8'h40, 8'h00, 1'b0, 2'd0, lat, ie);
        chk("R9", "push wrap sp", sp_out, 8'h01);
        chk("R9", "push wrap ram00", ram[8'h00], 8'h02);
        chk("R9", "push wrap ram01", ram[8'h01], 8'h00);
        chk("R9", "push wrap pc", pc_out, 16'h0040);
    endtask

    task automatic t_busy();
        int lat;
        @(negedge clk);
        op_sel = 3'd1; cur_pc = 16'h0400; page_bits = 3'd2; byte2 = 8'h00;
        byte3 = 8'h00; start = 1'b1;
        @(negedge clk);
        op_sel = 3'd2; byte2 = 8'hFF; byte3 = 8'hFF; cur_pc = 16'h7777;
        lat = 1;
        @(negedge clk);
        lat++;
        @(negedge clk);
        start = 1'b0;
        lat++;
        while (!done && lat < 16) begin
            @(negedge clk);
            lat++;
        end
        chk("R11", "pc unaffected", pc_out, 16'h0200);
        chk("R11", "sp", sp_out, 8'h03);
        chk("R11", "ram02", ram[8'h02], 8'h02);
        chk("R11", "ram03", ram[8'h03], 8'h04);
        chk("R11", "latency", lat, 4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) ram[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_abs_call();
        t_abs_jump();
        t_long_call();
        t_long_jump();
        t_branch();
        t_return();
        t_reti();
        t_wrap();
        t_busy();
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule